// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an 8-bit timer whose counter runs in a triangle. It counts up from zero to a TOP value and then back down to zero, over and over. A three-bit waveform mode input picks where TOP comes from. In one mode TOP is the full-scale value 255. In the other, TOP is the active compare value of channel A. Any other mode value freezes the timer. The counter moves only on cycles where the count enable is high.

The block has two compare channels, A and B. Each has a write buffer and an active compare value. The active value loads from the buffer once per period, at TOP, so a new duty cycle always starts on a period boundary. Each channel drives a waveform output. A two-bit output mode field per channel sets what happens on a compare match: the output is disconnected, driven non-inverted, driven inverted, or (channel A only) toggled.

An overflow flag marks each arrival at zero. Each channel has its own compare flag. Software clears the flags by writing ones. The symmetric waveform keeps the pulse centre fixed as the duty changes, which suits motor and power-stage drive.

Top module: `pwmt_timer`

## Requirements
- R1: The counter, outputs and flags change only on an enabled tick. A tick is a cycle where `cnt_en` is 1 and `wf_mode` is 1 or 5. All other cycles hold every state.
- R2: TOP is 255 when `wf_mode` is 1. TOP is channel A's active compare value when `wf_mode` is 5.
- R3: While counting up below TOP, each tick adds one. At TOP the counter stays for one tick and then counts down. At zero it stays for one tick and then counts up. One period is therefore 2*TOP ticks. `count_down_o` is 1 while the counter is descending.
- R4: Output mode 2 (non-inverting) acts on a tick where the count equals the active compare value. If the next step is upward (this includes the bottom), the output clears. If the next step is downward (this includes TOP), the output sets. The new output is visible in the cycle after that tick. A compare value of k gives 2k high ticks per 2*TOP-tick period: k=0 is always low and k=TOP is always high.
- R5: Output mode 3 (inverting) does the opposite of R4. It sets on an upward-step match and clears on a downward-step match, so a compare value of k gives 2*TOP-2k high ticks per period.
- R6: Output mode 0 leaves the output unchanged on every match.
- R7: When channel A's output mode is 1 and bit 2 of `wf_mode` is 1, output A toggles on every match. In any other case mode 1 acts like mode 0, and channel B never toggles.
- R8: A compare write goes into a buffer. The active compare value loads from the buffer only on the tick where the counter is at TOP while counting up. A write made in the same cycle as that load takes effect at the next TOP.
- R9: `ovf_flag_o` sets in the cycle after a tick that moves the count from a nonzero value to zero.
- R10: A channel's compare flag sets in the cycle after a tick where the count equals that channel's active compare value.
- R11: Writing a 1 to `flag_clr` clears a flag. Bit 0 clears overflow, bit 1 clears compare A and bit 2 clears compare B. If a flag is set and cleared in the same cycle, the set wins.
- R12: Synchronous reset `rst` sets to zero the counter, the count direction (up), both outputs, all flags, both buffers and both active compare values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable (timer tick qualifier) |
| wf_mode | input | 3 | Waveform mode; 1 = TOP 255, 5 = TOP from channel A |
| out_mode_a | input | 2 | Channel A output mode (0 off, 1 toggle, 2 non-inverting, 3 inverting) |
| out_mode_b | input | 2 | Channel B output mode (0 off, 1 off, 2 non-inverting, 3 inverting) |
| cmp_a_we | input | 1 | Write `cmp_wdata` into channel A buffer |
| cmp_b_we | input | 1 | Write `cmp_wdata` into channel B buffer |
| cmp_wdata | input | 8 | Compare write data |
| flag_clr | input | 3 | Write-one-to-clear: bit0 overflow, bit1 compare A, bit2 compare B |
| count_o | output | 8 | Current counter value |
| count_down_o | output | 1 | 1 while the counter is descending |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| ovf_flag_o | output | 1 | Bottom-reached flag |
| cmp_a_flag_o | output | 1 | Channel A compare flag |
| cmp_b_flag_o | output | 1 | Channel B compare flag |

## Verification
Every result of a tick is registered, so the counter, direction, waveforms and all three flags move on the edge that consumes the tick and can be read one cycle later. The bench keeps a reference model that it steps on each rising edge with the same inputs the design samples. It compares all seven outputs at the next falling edge, so every check falls in the first cycle where the new value is due. Buffered compare writes show no effect until the next TOP. The bench tests this by writing during an up-ramp and sampling the output in the cycle after the old match point. The duty checks count high cycles over a window of one full period, and they start only after more than a period has passed since the last compare or mode change.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_CLR_UP = 2'd2,
        OUT_SET_UP = 2'd3
    } out_mode_e;

    localparam logic [2:0] WF_PC_FULL = 3'd1;
    localparam logic [2:0] WF_PC_REG  = 3'd5;

    function automatic logic is_phase_mode(input logic [2:0] m);
        return (m == WF_PC_FULL) || (m == WF_PC_REG);
    endfunction

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         down_o,
    output logic         next_down_o,
    output logic         at_top_o,
    output logic         bottom_hit_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_state_t;

    cnt_state_t s_q, s_d, s_n;
    logic       at_top;

    always_comb begin
        s_n    = s_q;
        at_top = !s_q.down && (s_q.cnt >= top_i);
        if (!s_q.down) begin
            if (at_top) begin
                s_n.down = (top_i != '0);
                s_n.cnt  = (top_i == '0) ? '0 : s_q.cnt - W'(1);
            end else begin
                s_n.down = 1'b0;
                s_n.cnt  = s_q.cnt + W'(1);
            end
        end else begin
            if (s_q.cnt == '0) begin
                s_n.down = 1'b0;
                s_n.cnt  = (top_i != '0) ? W'(1) : '0;
            end else begin
                s_n.down = 1'b1;
                s_n.cnt  = s_q.cnt - W'(1);
            end
        end
        s_d = tick_i ? s_n : s_q;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt_o        = s_q.cnt;
    assign down_o       = s_q.down;
    assign next_down_o  = s_n.down;
    assign at_top_o     = at_top;
    assign bottom_hit_o = tick_i && (s_q.cnt != '0) && (s_n.cnt == '0);

    // R1: no tick, no movement
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(s_q.cnt) && $stable(s_q.down)));
    // R3: up-ramp increments by one
    p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !at_top && !s_q.down) |=> (s_q.cnt == $past(s_q.cnt) + W'(1)));
    // R3: turn around at TOP
    p_top_turn_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && at_top && (top_i != '0)) |=> s_q.down);
    // R3: turn around at BOTTOM
    p_bottom_turn_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && s_q.down && (s_q.cnt == '0)) |=> !s_q.down);

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int W         = 8,
    parameter bit TOGGLE_OK = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] cnt_i,
    input  logic         next_down_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [1:0]   out_mode_i,
    input  logic         toggle_en_i,
    output logic [W-1:0] act_o,
    output logic         wave_o,
    output logic         match_o
);
    typedef struct packed {
        logic [W-1:0] buf_v;
        logic [W-1:0] act;
        logic         wave;
    } ch_state_t;

    ch_state_t s_q, s_d;
    out_mode_e om;
    logic      match;

    assign om = out_mode_e'(out_mode_i);

    always_comb begin
        s_d   = s_q;
        match = tick_i && (cnt_i == s_q.act);
        if (wr_en_i)         s_d.buf_v = wr_data_i;
        if (tick_i && load_i) s_d.act  = s_q.buf_v;
        if (match) begin
            unique case (om)
                OUT_CLR_UP: s_d.wave = next_down_i;
                OUT_SET_UP: s_d.wave = !next_down_i;
                OUT_TOGGLE: if (TOGGLE_OK && toggle_en_i) s_d.wave = !s_q.wave;
                default:    s_d.wave = s_q.wave;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign act_o   = s_q.act;
    assign wave_o  = s_q.wave;
    assign match_o = match;

    // R4: non-inverting up-step match clears
    p_noninv_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && (out_mode_i == 2'd2) && (cnt_i == s_q.act) && !next_down_i) |=> !s_q.wave);
    // R5: inverting down-step match clears
    p_inv_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (tick_i && (out_mode_i == 2'd3) && (cnt_i == s_q.act) && next_down_i) |=> !s_q.wave);
    // R6: disconnected output holds
    p_off_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_mode_i == 2'd0) |=> $stable(s_q.wave));
    // R7: toggle mode without permission holds
    p_no_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        ((out_mode_i == 2'd1) && !(TOGGLE_OK && toggle_en_i)) |=> $stable(s_q.wave));
    // R8: active value moves only on TOP load
    p_act_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(tick_i && load_i) |=> $stable(s_q.act));

endmodule

// File: rtl/pwmt_flags.sv
module pwmt_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q, flag_d;

    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R9, R10: a set event is visible next cycle
    p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
    // R11: write-one clears when no set competes
    p_flag_clr_r11: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [2:0]       wf_mode,
    input  logic [1:0]       out_mode_a,
    input  logic [1:0]       out_mode_b,
    input  logic             cmp_a_we,
    input  logic             cmp_b_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [2:0]       flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             count_down_o,
    output logic             wave_a_o,
    output logic             wave_b_o,
    output logic             ovf_flag_o,
    output logic             cmp_a_flag_o,
    output logic             cmp_b_flag_o
);
    localparam int NUM_CH = 2;
    localparam int NUM_FL = NUM_CH + 1;

    logic             tick;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] cnt;
    logic             down, next_down, at_top, bottom_hit;

    logic [CNT_W-1:0] act_v  [NUM_CH];
    logic [1:0]       mode_v [NUM_CH];
    logic [NUM_CH-1:0] we_v, wave_v, match_v;
    logic [NUM_FL-1:0] flags;

    assign tick      = cnt_en && is_phase_mode(wf_mode);
    assign top_val   = (wf_mode == WF_PC_REG) ? act_v[0] : '1;
    assign mode_v[0] = out_mode_a;
    assign mode_v[1] = out_mode_b;
    assign we_v      = {cmp_b_we, cmp_a_we};

    pwmt_counter #(.W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .top_i        (top_val),
        .cnt_o        (cnt),
        .down_o       (down),
        .next_down_o  (next_down),
        .at_top_o     (at_top),
        .bottom_hit_o (bottom_hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwmt_channel #(.W(CNT_W), .TOGGLE_OK(i == 0)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .tick_i      (tick),
            .load_i      (at_top),
            .cnt_i       (cnt),
            .next_down_i (next_down),
            .wr_en_i     (we_v[i]),
            .wr_data_i   (cmp_wdata),
            .out_mode_i  (mode_v[i]),
            .toggle_en_i (wf_mode[2]),
            .act_o       (act_v[i]),
            .wave_o      (wave_v[i]),
            .match_o     (match_v[i])
        );
    end

    pwmt_flags #(.N(NUM_FL)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  ({match_v, bottom_hit}),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    assign count_o      = cnt;
    assign count_down_o = down;
    assign wave_a_o     = wave_v[0];
    assign wave_b_o     = wave_v[1];
    assign ovf_flag_o   = flags[0];
    assign cmp_a_flag_o = flags[1];
    assign cmp_b_flag_o = flags[2];

    // R2: full-scale TOP in mode 1
    p_full_top_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && (wf_mode == WF_PC_FULL) && !down && (cnt == '1)) |=> count_down_o);

endmodule

// File: tb/pwmt_timer_tb_top.sv
module pwmt_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [2:0] wf_mode = 3'd0;
    logic [1:0] out_mode_a = 2'd0, out_mode_b = 2'd0;
    logic       cmp_a_we = 1'b0, cmp_b_we = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic [2:0] flag_clr = 3'd0;
    logic [7:0] count_o;
    logic       count_down_o, wave_a_o, wave_b_o;
    logic       ovf_flag_o, cmp_a_flag_o, cmp_b_flag_o;

    int checks = 0, errors = 0;
    string tag = "R4";

    // reference model state
    logic [7:0] m_cnt;  logic m_down;
    logic [7:0] m_buf [2];  logic [7:0] m_act [2];
    logic [1:0] m_wave; logic [2:0] m_flags;

    // window counters
    bit meas_on = 0;
    int hi_a = 0, hi_b = 0, tr_a = 0, tr_b = 0;
    logic prev_a = 0, prev_b = 0;

    always #4 clk = ~clk;

    pwmt_timer dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors <= 30) $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        logic tick, ndown, ovf; logic [7:0] top, ncnt, c; logic [1:0] om; logic [2:0] set;
        if (rst) begin
            m_cnt = 0; m_down = 0; m_wave = 0; m_flags = 0;
            for (int i = 0; i < 2; i++) begin m_buf[i] = 0; m_act[i] = 0; end
            return;
        end
        tick = cnt_en && (wf_mode == 3'd1 || wf_mode == 3'd5);
        top  = (wf_mode == 3'd5) ? m_act[0] : 8'hFF;
        set  = 0;
        ncnt = m_cnt; ndown = m_down;
        if (tick) begin
            c = m_cnt;
            if (!m_down && c >= top) begin
                ndown = (top != 0); ncnt = (top == 0) ? 8'd0 : c - 8'd1;
                m_act[0] = m_buf[0]; m_act[1] = m_buf[1];
            end else if (!m_down) begin
                ncnt = c + 8'd1; ndown = 0;
            end else if (c == 0) begin
                ndown = 0; ncnt = (top != 0) ? 8'd1 : 8'd0;
            end else begin
                ncnt = c - 8'd1; ndown = 1;
            end
            ovf = (c != 0) && (ncnt == 0);
            set[0] = ovf;
            for (int i = 0; i < 2; i++) begin
                // compare against active value before this edge's load
                logic [7:0] a;
                a = (!m_down && c >= top) ? m_act_prev[i] : m_act[i];
                if (c == a) begin
                    set[i+1] = 1;
                    om = (i == 0) ? out_mode_a : out_mode_b;
                    case (om)
                        2'd2: m_wave[i] = ndown;
                        2'd3: m_wave[i] = !ndown;
                        2'd1: if (i == 0 && wf_mode[2]) m_wave[i] = !m_wave[i];
                        default: ;
                    endcase
                end
            end
        end
        m_cnt = ncnt; m_down = ndown;
        if (cmp_a_we) m_buf[0] = cmp_wdata;
        if (cmp_b_we) m_buf[1] = cmp_wdata;
        m_flags = (m_flags & ~flag_clr) | set;
    endtask

    logic [7:0] m_act_prev [2];

    task automatic cycle();
        @(posedge clk);
        m_act_prev[0] = m_act[0]; m_act_prev[1] = m_act[1];
        model_step();
        @(negedge clk);
        check("R3 count", count_o, m_cnt);
        check("R3 direction", count_down_o, m_down);
        check({tag, " wave A"}, wave_a_o, m_wave[0]);
        check({tag, " wave B"}, wave_b_o, m_wave[1]);
        check("R9 overflow flag", ovf_flag_o, m_flags[0]);
        check("R10/R11 compare A flag", cmp_a_flag_o, m_flags[1]);
        check("R10/R11 compare B flag", cmp_b_flag_o, m_flags[2]);
        if (meas_on) begin
            hi_a += wave_a_o; hi_b += wave_b_o;
            tr_a += (wave_a_o != prev_a); tr_b += (wave_b_o != prev_b);
        end
        prev_a = wave_a_o; prev_b = wave_b_o;
        cmp_a_we = 0; cmp_b_we = 0; flag_clr = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic write_cmp(input bit ch_b, input logic [7:0] v);
        cmp_wdata = v;
        if (ch_b) cmp_b_we = 1; else cmp_a_we = 1;
        cycle();
    endtask

    task automatic measure(input int n);
        hi_a = 0; hi_b = 0; tr_a = 0; tr_b = 0; meas_on = 1;
        run(n);
        meas_on = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        m_act_prev[0] = 0; m_act_prev[1] = 0;
        run(3);
        // R12 reset state
        check("R12 reset count", count_o, 0);
        check("R12 reset direction", count_down_o, 0);
        check("R12 reset waves", {wave_a_o, wave_b_o}, 0);
        check("R12 reset flags", {ovf_flag_o, cmp_a_flag_o, cmp_b_flag_o}, 0);
        rst = 0;

        // mode 5, TOP = 20, non-inverting B at 7
        wf_mode = 3'd5; cnt_en = 1; out_mode_a = 2'd2; out_mode_b = 2'd2; tag = "R4";
        write_cmp(0, 8'd20); write_cmp(1, 8'd7);
        run(100); measure(40);
        check("R4 duty k=7 top=20", hi_b, 14);
        check("R2 TOP from channel A: A never high past own TOP", hi_a, 40);
        write_cmp(1, 8'd0); run(100); measure(40);
        check("R4 duty k=0 always low", hi_b, 0);
        write_cmp(1, 8'd20); run(100); measure(40);
        check("R4 duty k=TOP always high", hi_b, 40);
        tag = "R5"; out_mode_b = 2'd3;
        write_cmp(1, 8'd7); run(100); measure(40);
        check("R5 inverted duty k=7", hi_b, 26);

        // R8 buffered write during up-ramp
        tag = "R8"; out_mode_b = 2'd2;
        run(60);
        for (int i = 0; i < 100 && !(count_o == 8'd3 && !count_down_o); i++) cycle();
        write_cmp(1, 8'd15);
        for (int i = 0; i < 100 && !(count_o == 8'd8 && !count_down_o); i++) cycle();
        check("R8 old compare still active before TOP", wave_b_o, 0);
        run(100);

        // R1 hold when disabled or in other modes
        tag = "R1"; begin
            logic [7:0] c0;
            cnt_en = 0; run(1); c0 = count_o; run(20);
            check("R1 enable low holds count", count_o, c0);
            cnt_en = 1; wf_mode = 3'd2; run(1); c0 = count_o; run(20);
            check("R1 other mode holds count", count_o, c0);
            wf_mode = 3'd5;
        end

        // R6 disconnected output, R7 toggle on A
        tag = "R7"; out_mode_a = 2'd1; out_mode_b = 2'd0;
        write_cmp(0, 8'd10); run(60); measure(40);
        check("R7 toggle A twice in two periods", tr_a, 2);
        check("R6 B disconnected no transitions", tr_b, 0);
        wf_mode = 3'd1; run(20); measure(600);
        check("R7 no toggle when wf bit2 clear", tr_a, 0);

        // R2 full-scale TOP, non-inverting A at 128
        tag = "R2"; out_mode_a = 2'd2;
        write_cmp(0, 8'd128); run(600); measure(510);
        check("R2 full-scale duty k=128", hi_a, 256);

        // R11 clear and R9 overflow seen
        tag = "R11";
        flag_clr = 3'b111; cycle();
        run(600);
        check("R9 overflow flag after bottom", ovf_flag_o, 1);

        // constrained random mix
        tag = "R4/R5/R6/R7";
        for (int n = 0; n < 20000; n++) begin
            cnt_en = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 199) == 0) begin
                case ($urandom_range(0, 3))
                    0: wf_mode = 3'd1;
                    1: wf_mode = 3'd0;
                    default: wf_mode = 3'd5;
                endcase
            end
            if ($urandom_range(0, 63) == 0) out_mode_a = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 63) == 0) out_mode_b = 2'($urandom_range(0, 3));
            cmp_wdata = 8'($urandom_range(0, 40));
            cmp_a_we = ($urandom_range(0, 31) == 0);
            cmp_b_we = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 3) == 0) flag_clr = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 4999) == 0) rst = 1;
            cycle();
            rst = 0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule